// File: doc/BRIEF.md
# Tag-Wakeup Reservation Station Array

This block holds instructions between in-order dispatch and out-of-order issue. It has a small set of stations, five by default. Each station is tied to one functional-unit class and is named by a tag equal to its station number, counting from 1. Tag 0 is reserved to mean "operand value present". Dispatch places an instruction into the lowest-numbered free station of the requested class. For each source, dispatch supplies either a value (tag 0) or the tag of the station that will produce it. A station waiting on a tag watches the block's result bus. When the bus tag matches, the station copies the bus value and clears the tag. This gives copy-based renaming: once a value is captured, later writes to the source register cannot disturb it.

Dispatch is a valid/ready stream. While `disp_ready` is low, the producer must hold `disp_valid` and every payload field stable. That stall also holds every younger instruction behind it. Writeback names a station and supplies its result. The block frees the station and, unless it is the store station, drives the result bus in the same cycle. The bus is used both inside the block and outside it. Issue is a request by tag. It is granted only when that station is ready, and it returns the operands, with any value arriving on the bus in that cycle forwarded directly.

Top module: `tag_wakeup_rs`

## Requirements
- R1: While reset is held and in the first cycle after it, every station is free. `rdy` is all zero, `bus_valid` is 0 and `disp_ready` is 1 for every class.
- R2: Class codes are 0 integer, 1 load, 2 store and 3 floating point. With the default layout these map to stations 1, 2, 3 and 4–5. Dispatch allocates the lowest-numbered free station of `disp_cls`, and `disp_tag` gives that station number.
- R3: `disp_ready` is 0 when no station of `disp_cls` is free or being freed. In that cycle nothing is allocated. Availability of the other classes is not affected.
- R4: A source dispatched with tag 0 keeps the supplied value. A station whose two source tags are both 0 raises its `rdy` bit in the cycle after dispatch.
- R5: A waiting source captures `bus_value` when `bus_tag` equals its stored tag. In that same cycle the station's `rdy` bit already counts that source as present, and an issue returns the bus value for it.
- R6: If a source is dispatched with a nonzero tag in the same cycle the bus carries that tag, the bus value is stored and the tag is recorded as 0.
- R7: A station written back in a cycle counts as free for dispatch in that same cycle. It can be reallocated at that clock edge.
- R8: A writeback of a busy non-store station sets `bus_valid`, `bus_tag = wb_tag` and `bus_value = wb_value` combinationally. A writeback of the store station (class 2) frees it without driving the bus. A writeback naming an idle station, tag 0 or a tag above the station count has no effect.
- R9: `iss_grant` rises only when `iss_tag` names a ready station. It returns that station's op, destination and operands. The station's `rdy` bit is 0 from the next cycle until it is reallocated. A request for a station that is not ready is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | 1 | Dispatch payload valid |
| disp_ready | output | 1 | A station of `disp_cls` can accept now |
| disp_cls | input | 2 | Requested unit class |
| disp_op | input | OPW | Operation code |
| disp_dst | input | REGW | Destination register |
| disp_t1 | input | TAGW | Source 1 producer tag, 0 = value given |
| disp_v1 | input | DW | Source 1 value |
| disp_t2 | input | TAGW | Source 2 producer tag, 0 = value given |
| disp_v2 | input | DW | Source 2 value |
| disp_tag | output | TAGW | Station number that would be allocated |
| wb_valid | input | 1 | Writeback request |
| wb_tag | input | TAGW | Station being written back |
| wb_value | input | DW | Result value |
| bus_valid | output | 1 | Result bus carries a broadcast |
| bus_tag | output | TAGW | Broadcast tag |
| bus_value | output | DW | Broadcast value |
| rdy | output | NUM_RS | Per-station ready bits, bit i = station i+1 |
| iss_req | input | 1 | Issue request |
| iss_tag | input | TAGW | Station requested for issue |
| iss_grant | output | 1 | Issue accepted |
| iss_op | output | OPW | Issued op |
| iss_dst | output | REGW | Issued destination |
| iss_v1 | output | DW | Issued source 1 |
| iss_v2 | output | DW | Issued source 2 |

## Verification
The first directed pattern fills both floating-point stations and then asks for a third. This separates a correct lowest-first choice and stall from an allocator that overwrites or skips a station. A second pattern puts a writeback, a dispatch that reuses the freed station while depending on it, and an issue of a waiting station into one cycle. This exposes any missing bus bypass in wakeup, capture or operand return. A store writeback and a writeback of an idle station show whether the bus is wrongly driven. Random mixes of dispatch, writeback and issue, with out-of-range tags and held stalls, are then compared cycle by cycle against a reference model in the bench.

// File: rtl/rs_pkg.sv
package rs_pkg;
  localparam int CLS_W = 2;
  typedef enum logic [CLS_W-1:0] {
    CLS_INT  = 2'd0,
    CLS_LOAD = 2'd1,
    CLS_STOR = 2'd2,
    CLS_FLT  = 2'd3
  } unit_cls_e;
endpackage

// File: rtl/rs_operand.sv
// One source slot: holds either a value (tag 0) or a pending producer tag.
module rs_operand #(
  parameter int DW   = 32,
  parameter int TAGW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [TAGW-1:0] ld_tag,
  input  logic [DW-1:0]   ld_val,
  input  logic            bus_valid,
  input  logic [TAGW-1:0] bus_tag,
  input  logic [DW-1:0]   bus_val,
  output logic            ok,
  output logic [DW-1:0]   val
);
  logic [TAGW-1:0] tag_q;
  logic [DW-1:0]   val_q;
  logic            hit_now;
  logic            hit_load;

  assign hit_now  = bus_valid && (tag_q != '0) && (bus_tag == tag_q);
  assign hit_load = bus_valid && (ld_tag != '0) && (bus_tag == ld_tag);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q <= '0;
      val_q <= '0;
    end else if (load) begin
      tag_q <= hit_load ? '0 : ld_tag;
      val_q <= hit_load ? bus_val : ld_val;
    end else if (hit_now) begin
      tag_q <= '0;
      val_q <= bus_val;
    end
  end

  assign ok  = (tag_q == '0) || hit_now;
  assign val = hit_now ? bus_val : val_q;
endmodule

// File: rtl/rs_entry.sv
// One station: status, op fields and two source slots.
module rs_entry #(
  parameter int DW   = 32,
  parameter int TAGW = 3,
  parameter int OPW  = 4,
  parameter int REGW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            alloc,
  input  logic            free,
  input  logic            take,
  input  logic [OPW-1:0]  d_op,
  input  logic [REGW-1:0] d_dst,
  input  logic [TAGW-1:0] d_t1,
  input  logic [DW-1:0]   d_v1,
  input  logic [TAGW-1:0] d_t2,
  input  logic [DW-1:0]   d_v2,
  input  logic            bus_valid,
  input  logic [TAGW-1:0] bus_tag,
  input  logic [DW-1:0]   bus_val,
  output logic            busy,
  output logic            ready,
  output logic [OPW-1:0]  op,
  output logic [REGW-1:0] dst,
  output logic [DW-1:0]   v1,
  output logic [DW-1:0]   v2
);
  logic issued_q;
  logic ok1, ok2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      issued_q <= 1'b0;
      op       <= '0;
      dst      <= '0;
    end else if (alloc) begin
      busy     <= 1'b1;
      issued_q <= 1'b0;
      op       <= d_op;
      dst      <= d_dst;
    end else begin
      if (free) busy <= 1'b0;
      if (take) issued_q <= 1'b1;
    end
  end

  rs_operand #(.DW(DW), .TAGW(TAGW)) u_src1 (
    .clk(clk), .rst_n(rst_n), .load(alloc), .ld_tag(d_t1), .ld_val(d_v1),
    .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_val(bus_val),
    .ok(ok1), .val(v1)
  );

  rs_operand #(.DW(DW), .TAGW(TAGW)) u_src2 (
    .clk(clk), .rst_n(rst_n), .load(alloc), .ld_tag(d_t2), .ld_val(d_v2),
    .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_val(bus_val),
    .ok(ok2), .val(v2)
  );

  assign ready = busy && !issued_q && ok1 && ok2;
endmodule

// File: rtl/rs_alloc.sv
// Picks the lowest-numbered available station of the requested class.
module rs_alloc #(
  parameter int N     = 5,
  parameter int CLS_W = 2,
  parameter int TAGW  = 3,
  parameter logic [N*CLS_W-1:0] CLS_MAP = '0
) (
  input  logic [N-1:0]     avail,
  input  logic [CLS_W-1:0] want,
  output logic [N-1:0]     grant,
  output logic             found,
  output logic [TAGW-1:0]  tag
);
  always_comb begin
    grant = '0;
    found = 1'b0;
    tag   = '0;
    for (int i = 0; i < N; i++) begin
      if (!found && avail[i] && (CLS_MAP[i*CLS_W +: CLS_W] == want)) begin
        grant[i] = 1'b1;
        found    = 1'b1;
        tag      = TAGW'(i + 1);
      end
    end
  end
endmodule

// File: rtl/tag_wakeup_rs.sv
module tag_wakeup_rs
  import rs_pkg::*;
#(
  parameter int NUM_RS = 5,
  parameter int DW     = 32,
  parameter int OPW    = 4,
  parameter int REGW   = 5,
  parameter logic [NUM_RS*CLS_W-1:0] RS_CLASS = 10'b11_11_10_01_00,
  parameter int TAGW   = $clog2(NUM_RS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              disp_valid,
  output logic              disp_ready,
  input  logic [CLS_W-1:0]  disp_cls,
  input  logic [OPW-1:0]    disp_op,
  input  logic [REGW-1:0]   disp_dst,
  input  logic [TAGW-1:0]   disp_t1,
  input  logic [DW-1:0]     disp_v1,
  input  logic [TAGW-1:0]   disp_t2,
  input  logic [DW-1:0]     disp_v2,
  output logic [TAGW-1:0]   disp_tag,
  input  logic              wb_valid,
  input  logic [TAGW-1:0]   wb_tag,
  input  logic [DW-1:0]     wb_value,
  output logic              bus_valid,
  output logic [TAGW-1:0]   bus_tag,
  output logic [DW-1:0]     bus_value,
  output logic [NUM_RS-1:0] rdy,
  input  logic              iss_req,
  input  logic [TAGW-1:0]   iss_tag,
  output logic              iss_grant,
  output logic [OPW-1:0]    iss_op,
  output logic [REGW-1:0]   iss_dst,
  output logic [DW-1:0]     iss_v1,
  output logic [DW-1:0]     iss_v2
);
  logic [NUM_RS-1:0] busy, freeing, avail, grant, alloc, take, loud;
  logic [OPW-1:0]    e_op  [NUM_RS];
  logic [REGW-1:0]   e_dst [NUM_RS];
  logic [DW-1:0]     e_v1  [NUM_RS];
  logic [DW-1:0]     e_v2  [NUM_RS];

  for (genvar g = 0; g < NUM_RS; g++) begin : g_st
    localparam logic [TAGW-1:0] MY_TAG = TAGW'(g + 1);
    localparam bit IS_STORE = (RS_CLASS[g*CLS_W +: CLS_W] == CLS_STOR);

    assign freeing[g] = wb_valid && (wb_tag == MY_TAG) && busy[g];
    assign loud[g]    = freeing[g] && !IS_STORE;
    assign take[g]    = iss_req && (iss_tag == MY_TAG) && rdy[g];

    rs_entry #(.DW(DW), .TAGW(TAGW), .OPW(OPW), .REGW(REGW)) u_ent (
      .clk(clk), .rst_n(rst_n),
      .alloc(alloc[g]), .free(freeing[g]), .take(take[g]),
      .d_op(disp_op), .d_dst(disp_dst),
      .d_t1(disp_t1), .d_v1(disp_v1), .d_t2(disp_t2), .d_v2(disp_v2),
      .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_val(bus_value),
      .busy(busy[g]), .ready(rdy[g]),
      .op(e_op[g]), .dst(e_dst[g]), .v1(e_v1[g]), .v2(e_v2[g])
    );
  end

  assign avail = ~busy | freeing;

  rs_alloc #(.N(NUM_RS), .CLS_W(CLS_W), .TAGW(TAGW), .CLS_MAP(RS_CLASS)) u_alloc (
    .avail(avail), .want(disp_cls), .grant(grant), .found(disp_ready), .tag(disp_tag)
  );

  assign alloc = grant & {NUM_RS{disp_valid}};

  assign bus_valid = |loud;
  assign bus_tag   = bus_valid ? wb_tag : '0;
  assign bus_value = bus_valid ? wb_value : '0;

  assign iss_grant = |take;

  always_comb begin
    iss_op  = '0;
    iss_dst = '0;
    iss_v1  = '0;
    iss_v2  = '0;
    for (int i = 0; i < NUM_RS; i++) begin
      if (take[i]) begin
        iss_op  = iss_op  | e_op[i];
        iss_dst = iss_dst | e_dst[i];
        iss_v1  = iss_v1  | e_v1[i];
        iss_v2  = iss_v2  | e_v2[i];
      end
    end
  end
endmodule

// File: rtl/tag_wakeup_rs_chk.sv
module tag_wakeup_rs_chk
  import rs_pkg::*;
#(
  parameter int NUM_RS = 5,
  parameter logic [NUM_RS*CLS_W-1:0] RS_CLASS = 10'b11_11_10_01_00,
  parameter int TAGW   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              disp_valid,
  input logic              disp_ready,
  input logic [CLS_W-1:0]  disp_cls,
  input logic [TAGW-1:0]   disp_tag,
  input logic              bus_valid,
  input logic [TAGW-1:0]   bus_tag,
  input logic [NUM_RS-1:0] rdy,
  input logic              iss_grant,
  input logic [TAGW-1:0]   iss_tag
);
  function automatic logic [CLS_W-1:0] cls_of(input logic [TAGW-1:0] t);
    cls_of = '0;
    for (int i = 0; i < NUM_RS; i++)
      if (t == TAGW'(i + 1)) cls_of = RS_CLASS[i*CLS_W +: CLS_W];
  endfunction

  function automatic logic bit_at(input logic [NUM_RS-1:0] v, input logic [TAGW-1:0] t);
    bit_at = 1'b0;
    for (int i = 0; i < NUM_RS; i++)
      if (t == TAGW'(i + 1)) bit_at = v[i];
  endfunction

  a_r1_reset_idle: assert property (@(posedge clk) !rst_n |=> (rdy == '0 && !bus_valid));

  a_r2_tag_in_class: assert property (@(posedge clk) disable iff (!rst_n)
    disp_ready |-> (disp_tag != '0 && cls_of(disp_tag) == disp_cls));

  a_r8_bus_legal: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> (bus_tag != '0 && cls_of(bus_tag) != CLS_STOR));

  a_r9_grant_ready: assert property (@(posedge clk) disable iff (!rst_n)
    iss_grant |-> bit_at(rdy, iss_tag));

  a_r9_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_grant && !(disp_valid && disp_ready && disp_tag == iss_tag))
      |=> !bit_at(rdy, $past(iss_tag)));
endmodule

bind tag_wakeup_rs tag_wakeup_rs_chk #(
  .NUM_RS(NUM_RS), .RS_CLASS(RS_CLASS), .TAGW(TAGW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_ready(disp_ready),
  .disp_cls(disp_cls), .disp_tag(disp_tag), .bus_valid(bus_valid),
  .bus_tag(bus_tag), .rdy(rdy), .iss_grant(iss_grant), .iss_tag(iss_tag)
);

// File: tb/sim_tag_wakeup_rs.sv
`timescale 1ns/1ps
module sim_tag_wakeup_rs;
  localparam int N = 5;
  localparam int TW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          d_valid, d_ready;
  logic [1:0]    d_cls;
  logic [3:0]    d_op;
  logic [4:0]    d_dst;
  logic [TW-1:0] d_t1, d_t2, d_tag;
  logic [31:0]   d_v1, d_v2;
  logic          w_valid;
  logic [TW-1:0] w_tag;
  logic [31:0]   w_val;
  logic          b_valid;
  logic [TW-1:0] b_tag;
  logic [31:0]   b_val;
  logic [N-1:0]  rdy;
  logic          i_req, i_grant;
  logic [TW-1:0] i_tag;
  logic [3:0]    i_op;
  logic [4:0]    i_dst;
  logic [31:0]   i_v1, i_v2;

  tag_wakeup_rs u0 (
    .clk(clk), .rst_n(rst_n),
    .disp_valid(d_valid), .disp_ready(d_ready), .disp_cls(d_cls), .disp_op(d_op),
    .disp_dst(d_dst), .disp_t1(d_t1), .disp_v1(d_v1), .disp_t2(d_t2), .disp_v2(d_v2),
    .disp_tag(d_tag), .wb_valid(w_valid), .wb_tag(w_tag), .wb_value(w_val),
    .bus_valid(b_valid), .bus_tag(b_tag), .bus_value(b_val), .rdy(rdy),
    .iss_req(i_req), .iss_tag(i_tag), .iss_grant(i_grant), .iss_op(i_op),
    .iss_dst(i_dst), .iss_v1(i_v1), .iss_v2(i_v2)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // reference model
  bit          m_busy [N];
  bit          m_iss  [N];
  logic [TW-1:0] m_t1 [N];
  logic [TW-1:0] m_t2 [N];
  logic [31:0] m_v1 [N];
  logic [31:0] m_v2 [N];
  logic [3:0]  m_op [N];
  logic [4:0]  m_dst [N];

  // snapshot of the last stepped cycle
  logic s_dr, s_bv, s_gr;
  logic [TW-1:0] s_dtag, s_bt;
  logic [31:0] s_bval, s_v1, s_v2;
  logic [N-1:0] s_rdy;

  function automatic int cls_of(int i);
    return (i == 0) ? 0 : (i == 1) ? 1 : (i == 2) ? 2 : 3;
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic idle();
    d_valid = 0; d_cls = 0; d_op = 0; d_dst = 0; d_t1 = 0; d_t2 = 0; d_v1 = 0; d_v2 = 0;
    w_valid = 0; w_tag = 0; w_val = 0; i_req = 0; i_tag = 0;
  endtask

  // Drives the current stimulus for one cycle, checks against the model, advances it.
  task automatic step();
    bit e_free [N];
    bit e_rdy [N];
    bit e_bv, e_dr, e_gr;
    int e_di, gi;
    logic [TW-1:0] e_bt;
    logic [31:0] e_bval;
    logic [N-1:0] e_rv;
    #1;
    e_bv = 0;
    for (int i = 0; i < N; i++) begin
      e_free[i] = w_valid && (int'(w_tag) == i + 1) && m_busy[i];
      if (e_free[i] && cls_of(i) != 2) e_bv = 1;
    end
    e_bt = e_bv ? w_tag : '0;
    e_bval = e_bv ? w_val : 32'h0;
    for (int i = 0; i < N; i++) begin
      e_rdy[i] = m_busy[i] && !m_iss[i] &&
                 (m_t1[i] == 0 || (e_bv && e_bt == m_t1[i])) &&
                 (m_t2[i] == 0 || (e_bv && e_bt == m_t2[i]));
      e_rv[i] = e_rdy[i];
    end
    e_dr = 0; e_di = -1;
    for (int i = 0; i < N; i++)
      if (!e_dr && cls_of(i) == int'(d_cls) && (!m_busy[i] || e_free[i])) begin
        e_dr = 1; e_di = i;
      end
    gi = int'(i_tag) - 1;
    e_gr = i_req && gi >= 0 && gi < N && e_rdy[gi];

    s_dr = d_ready; s_dtag = d_tag; s_bv = b_valid; s_bt = b_tag; s_bval = b_val;
    s_rdy = rdy; s_gr = i_grant; s_v1 = i_v1; s_v2 = i_v2;

    chk("R3", "disp_ready", 32'(d_ready), 32'(e_dr));
    if (e_dr) chk("R2", "disp_tag", 32'(d_tag), 32'(e_di + 1));
    chk("R8", "bus_valid", 32'(b_valid), 32'(e_bv));
    if (e_bv) begin
      chk("R8", "bus_tag", 32'(b_tag), 32'(e_bt));
      chk("R8", "bus_value", b_val, e_bval);
    end
    chk("R5", "rdy", 32'(rdy), 32'(e_rv));
    chk("R9", "iss_grant", 32'(i_grant), 32'(e_gr));
    if (e_gr) begin
      chk("R9", "iss_op", 32'(i_op), 32'(m_op[gi]));
      chk("R9", "iss_dst", 32'(i_dst), 32'(m_dst[gi]));
      chk("R5", "iss_v1", i_v1, (m_t1[gi] == 0) ? m_v1[gi] : e_bval);
      chk("R5", "iss_v2", i_v2, (m_t2[gi] == 0) ? m_v2[gi] : e_bval);
    end

    @(posedge clk);
    for (int i = 0; i < N; i++) begin
      if (d_valid && e_dr && e_di == i) begin
        m_busy[i] = 1; m_iss[i] = 0; m_op[i] = d_op; m_dst[i] = d_dst;
        if (d_t1 != 0 && e_bv && e_bt == d_t1) begin m_t1[i] = 0; m_v1[i] = e_bval; end
        else begin m_t1[i] = d_t1; m_v1[i] = d_v1; end
        if (d_t2 != 0 && e_bv && e_bt == d_t2) begin m_t2[i] = 0; m_v2[i] = e_bval; end
        else begin m_t2[i] = d_t2; m_v2[i] = d_v2; end
      end else begin
        if (m_t1[i] != 0 && e_bv && e_bt == m_t1[i]) begin m_t1[i] = 0; m_v1[i] = e_bval; end
        if (m_t2[i] != 0 && e_bv && e_bt == m_t2[i]) begin m_t2[i] = 0; m_v2[i] = e_bval; end
        if (e_free[i]) m_busy[i] = 0;
        if (e_gr && gi == i) m_iss[i] = 1;
      end
    end
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    bit hold;
    void'($urandom(32'd20240611));
    idle();
    for (int i = 0; i < N; i++) begin
      m_busy[i] = 0; m_iss[i] = 0; m_t1[i] = 0; m_t2[i] = 0;
      m_v1[i] = 0; m_v2[i] = 0; m_op[i] = 0; m_dst[i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    #1;
    chk("R1", "rdy", 32'(rdy), 32'h0);
    chk("R1", "bus_valid", 32'(b_valid), 32'h0);
    for (int c = 0; c < 4; c++) begin
      d_cls = 2'(c); #0.1;
      chk("R1", "disp_ready", 32'(d_ready), 32'h1);
    end
    @(negedge clk);

    // R2/R4: first FP goes to station 4
    idle(); d_valid = 1; d_cls = 3; d_op = 4'h1; d_dst = 5'd2; d_v1 = 32'd10; d_v2 = 32'd20;
    step();
    chk("R2", "first FP tag", 32'(s_dtag), 32'd4);
    // second FP waits on station 4, goes to station 5
    idle(); d_valid = 1; d_cls = 3; d_op = 4'h2; d_dst = 5'd3; d_t1 = 3'd4; d_v2 = 32'd30;
    step();
    chk("R2", "second FP tag", 32'(s_dtag), 32'd5);
    chk("R4", "station4 ready after dispatch", 32'(s_rdy[3]), 32'h1);
    // R3: third FP stalls, integer class still open
    idle(); d_valid = 1; d_cls = 3;
    step();
    chk("R3", "FP full stalls", 32'(s_dr), 32'h0);
    chk("R3", "station5 still waiting", 32'(s_rdy[4]), 32'h0);
    idle(); d_cls = 0;
    step();
    chk("R3", "integer class open", 32'(s_dr), 32'h1);
    // R9: issue station 4
    idle(); i_req = 1; i_tag = 3'd4;
    step();
    chk("R9", "grant st4", 32'(s_gr), 32'h1);
    chk("R4", "st4 v1", s_v1, 32'd10);
    chk("R4", "st4 v2", s_v2, 32'd20);
    // R9: unready request ignored, issued st4 drops
    idle(); i_req = 1; i_tag = 3'd5;
    step();
    chk("R9", "unready ignored", 32'(s_gr), 32'h0);
    chk("R9", "st4 ready dropped", 32'(s_rdy[3]), 32'h0);
    // R5/R6/R7/R8: writeback st4, reuse st4 depending on it, issue st5 on bypass
    idle(); w_valid = 1; w_tag = 3'd4; w_val = 32'd77;
    d_valid = 1; d_cls = 3; d_op = 4'h3; d_t1 = 3'd4; d_v2 = 32'd5;
    i_req = 1; i_tag = 3'd5;
    step();
    chk("R7", "reuse freeing station", 32'(s_dr), 32'h1);
    chk("R7", "reuse tag", 32'(s_dtag), 32'd4);
    chk("R8", "bus valid", 32'(s_bv), 32'h1);
    chk("R8", "bus value", s_bval, 32'd77);
    chk("R5", "wakeup same cycle", 32'(s_gr), 32'h1);
    chk("R5", "bypassed v1", s_v1, 32'd77);
    idle(); i_req = 1; i_tag = 3'd4;
    step();
    chk("R6", "captured at dispatch grant", 32'(s_gr), 32'h1);
    chk("R6", "captured v1", s_v1, 32'd77);
    // R8: store frees silently and is reusable at once
    idle(); d_valid = 1; d_cls = 2;
    step();
    chk("R2", "store tag", 32'(s_dtag), 32'd3);
    idle(); w_valid = 1; w_tag = 3'd3; w_val = 32'hABCD; d_cls = 2;
    step();
    chk("R8", "store silent", 32'(s_bv), 32'h0);
    chk("R7", "store reusable", 32'(s_dr), 32'h1);
    idle(); w_valid = 1; w_tag = 3'd1; w_val = 32'h55;
    step();
    chk("R8", "idle station silent", 32'(s_bv), 32'h0);

    // random phase
    hold = 0;
    for (int cyc = 0; cyc < 4000; cyc++) begin
      if (!hold) begin
        d_valid = ($urandom_range(0, 9) < 6);
        d_cls = 2'($urandom_range(0, 3));
        d_op = 4'($urandom); d_dst = 5'($urandom);
        d_t1 = ($urandom_range(0, 1) == 0) ? 3'd0 : 3'($urandom_range(1, 5));
        d_t2 = ($urandom_range(0, 1) == 0) ? 3'd0 : 3'($urandom_range(1, 5));
        d_v1 = $urandom; d_v2 = $urandom;
      end
      w_valid = ($urandom_range(0, 9) < 4);
      w_tag = 3'($urandom_range(0, 7));
      w_val = $urandom;
      i_req = ($urandom_range(0, 9) < 6);
      i_tag = 3'($urandom_range(0, 7));
      step();
      hold = d_valid && !s_dr;
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule